// File: doc/BRIEF.md
# Dual-Port Programmable Parallel I/O Interface

This block sits between a processor bus and a peripheral. It offers two byte-wide peripheral ports, a control register and a status register. The processor reaches all four through one bidirectional data bus. A chip enable, a two-bit register address and separate read and write strobes choose the register and the direction of each transfer. Everything is synchronous to one clock: a write takes effect on the clock edge where the write strobe is sampled. During a read the bus is driven for as long as the read strobe is held.

The control register sets the direction of each port at run time. A port set to output drives its register value onto its peripheral pins and enables its pin drivers. A port set to input captures the peripheral pins when its input strobe rises. The capture raises a "new data" flag in the status register. Reading that port's register clears the flag. This gives software a simple polled handshake with the peripheral.

Top module: `pio_dual_port`

## Requirements
- R1: When chip enable is low the bus is not driven and no register changes because of the processor strobes.
- R2: With chip enable high, register address 0 selects the port A register, 1 selects port B, 2 selects the control register and 3 selects the status register. A write stores the bus value on the clock edge where write is high and read is low.
- R3: While chip enable and read are high and write is low, the bus carries the selected register. Control reads back all 8 bits. Status reads as 0 in bits 7..2, the port B flag in bit 1 and the port A flag in bit 0.
- R4: Control bit 0 sets the direction of port A and control bit 1 sets the direction of port B, where 1 means output. A port's pin-enable output equals its direction bit, and its pin output always shows its register.
- R5: A port in input mode captures its input pins on the first clock edge at which its strobe is high after being low. The same edge sets its status flag.
- R6: A read of a port register clears that port's flag after the read edge. A capture in the same cycle wins and leaves the flag set.
- R7: Writes to the status register are ignored: control, port registers and flags keep their values.
- R8: A port in output mode ignores its input strobe: its register and flag do not change.
- R9: Read and write asserted together form no operation: the bus is not driven and no register is written.
- R10: Reset (synchronous, active high) clears control, both port registers and both flags, so both ports start as inputs with their pin drivers disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cs | input | 1 | Chip enable |
| cpu_addr | input | 2 | Register address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_data | inout | 8 | Bidirectional processor data bus |
| pa_in | input | 8 | Port A peripheral input pins |
| pa_stb | input | 1 | Port A input strobe |
| pa_out | output | 8 | Port A peripheral output value |
| pa_oe | output | 1 | Port A pin driver enable |
| pb_in | input | 8 | Port B peripheral input pins |
| pb_stb | input | 1 | Port B input strobe |
| pb_out | output | 8 | Port B peripheral output value |
| pb_oe | output | 1 | Port B pin driver enable |

## Verification
The hardest case to reach is a capture and a flag-clearing read of the same port in one clock cycle. The strobe edge has to fall exactly on the read edge, or the wrong priority goes unnoticed. The bench produces this case directly: it raises the strobe in the same half cycle in which it holds a read of that port. It then checks that the flag survives and that the register holds the new pin value. Random mixes of writes, reads, strobes and direction changes then cover the other orderings. The strobes land on ports in both modes.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    SEL_PORTA  = 2'd0,
    SEL_PORTB  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;
  localparam int NUM_PORTS = 2;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
(
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_op,
  output logic              wr_op,
  output logic [3:0]        wr_sel,
  output logic [3:0]        rd_sel
);
  always_comb begin
    rd_op  = cs && rd && !wr;
    wr_op  = cs && wr && !rd;
    wr_sel = '0;
    rd_sel = '0;
    for (int i = 0; i < 4; i++) begin
      wr_sel[i] = wr_op && (addr == ADDR_W'(i));
      rd_sel[i] = rd_op && (addr == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_out,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              rd_clear,
  input  logic [DATA_W-1:0] pin_in,
  input  logic              pin_stb,
  output logic [DATA_W-1:0] data_q,
  output logic              flag_q,
  output logic [DATA_W-1:0] pin_out
);
  logic stb_q;
  logic capture;

  assign capture = pin_stb && !stb_q && !dir_out;
  assign pin_out = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q  <= 1'b0;
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      stb_q <= pin_stb;
      if (capture)     data_q <= pin_in;
      else if (cpu_we) data_q <= cpu_wdata;
      if (capture)       flag_q <= 1'b1;
      else if (rd_clear) flag_q <= 1'b0;
    end
  end

  // R5 / R8: the flag may rise only after a strobe edge seen in input mode
  a_r5_flag_needs_capture: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(pin_stb && !dir_out));

  // R6: a read with no capture leaves the flag low
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_clear && !(pin_stb && !stb_q && !dir_out)) |=> !flag_q);

  // R8: output mode with no write keeps the register
  a_r8_out_mode_holds: assert property (@(posedge clk) disable iff (rst)
    (dir_out && !cpu_we) |=> $stable(data_q));
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_cs,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  inout  wire  [DATA_W-1:0] cpu_data,
  input  logic [DATA_W-1:0] pa_in,
  input  logic              pa_stb,
  output logic [DATA_W-1:0] pa_out,
  output logic              pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  input  logic              pb_stb,
  output logic [DATA_W-1:0] pb_out,
  output logic              pb_oe
);
  localparam int FLAG_PAD = DATA_W - NUM_PORTS;

  logic             rd_op, wr_op;
  logic [3:0]       wr_sel, rd_sel;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] port_q   [NUM_PORTS];
  logic [DATA_W-1:0] port_pin [NUM_PORTS];
  logic [DATA_W-1:0] port_out [NUM_PORTS];
  logic [NUM_PORTS-1:0] port_stb, flags;

  pio_decode u_dec (
    .cs(cpu_cs), .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .rd_op(rd_op), .wr_op(wr_op), .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  always_ff @(posedge clk) begin
    if (rst)                 ctrl_q <= '0;
    else if (wr_sel[SEL_CTRL]) ctrl_q <= cpu_data;
  end

  assign port_pin[0] = pa_in;
  assign port_pin[1] = pb_in;
  assign port_stb    = {pb_stb, pa_stb};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pio_port #(.DATA_W(DATA_W)) u_port (
      .clk(clk), .rst(rst),
      .dir_out(ctrl_q[p]),
      .cpu_we(wr_sel[p]),
      .cpu_wdata(cpu_data),
      .rd_clear(rd_sel[p]),
      .pin_in(port_pin[p]),
      .pin_stb(port_stb[p]),
      .data_q(port_q[p]),
      .flag_q(flags[p]),
      .pin_out(port_out[p])
    );
  end

  assign pa_out = port_out[0];
  assign pb_out = port_out[1];
  assign pa_oe  = ctrl_q[0];
  assign pb_oe  = ctrl_q[1];

  always_comb begin
    unique case (reg_sel_e'(cpu_addr))
      SEL_PORTA: rdata = port_q[0];
      SEL_PORTB: rdata = port_q[1];
      SEL_CTRL:  rdata = ctrl_q;
      default:   rdata = {{FLAG_PAD{1'b0}}, flags};
    endcase
  end

  assign cpu_data = rd_op ? rdata : {DATA_W{1'bz}};

  // R7: a status write leaves control untouched
  a_r7_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (cpu_cs && cpu_wr && !cpu_rd && cpu_addr == SEL_STATUS) |=> $stable(ctrl_q));

  // R9: read and write together never change control
  a_r9_collision_noop: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_wr) |=> $stable(ctrl_q));

  // R1: chip enable low never changes control
  a_r1_deselected_quiet: assert property (@(posedge clk) disable iff (rst)
    !cpu_cs |=> $stable(ctrl_q));
endmodule

// File: tb/pio_dual_port_test.sv
`timescale 1ns/1ps
module pio_dual_port_test;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rst, cs, rd, wr, sa, sb;
  logic [1:0] addr;
  logic [7:0] ain, bin, aout, bout, drv_val;
  logic aoe, boe, drv;
  wire  [7:0] bus;

  assign bus = drv ? drv_val : 8'bzzzzzzzz;
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (bus[i]);
  end

  pio_dual_port uut (
    .clk(clk), .rst(rst), .cpu_cs(cs), .cpu_addr(addr), .cpu_rd(rd),
    .cpu_wr(wr), .cpu_data(bus), .pa_in(ain), .pa_stb(sa), .pa_out(aout),
    .pa_oe(aoe), .pb_in(bin), .pb_stb(sb), .pb_out(bout), .pb_oe(boe)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_ctrl, m_a, m_b;
  logic m_fa, m_fb;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_a;
      2'd1: return m_b;
      2'd2: return m_ctrl;
      default: return {6'b0, m_fb, m_fa};
    endcase
  endfunction

  task automatic pins_chk();
    chk("R4 pa_out", aout, m_a);
    chk("R4 pb_out", bout, m_b);
    chk("R4 pa_oe", {7'b0, aoe}, {7'b0, m_ctrl[0]});
    chk("R4 pb_oe", {7'b0, boe}, {7'b0, m_ctrl[1]});
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    cs = 1; addr = a; wr = 1; rd = 0; drv = 1; drv_val = v;
    @(negedge clk);
    cs = 0; wr = 0; drv = 0;
    case (a)
      2'd0: m_a = v;
      2'd1: m_b = v;
      2'd2: m_ctrl = v;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [1:0] a, input string req);
    @(negedge clk);
    cs = 1; addr = a; rd = 1; wr = 0;
    #5 chk(req, bus, model_read(a));
    @(negedge clk);
    cs = 0; rd = 0;
    if (a == 2'd0) m_fa = 0;
    if (a == 2'd1) m_fb = 0;
  endtask

  task automatic strobe(input bit port_b, input logic [7:0] v);
    @(negedge clk);
    if (port_b) begin bin = v; sb = 1; end else begin ain = v; sa = 1; end
    @(negedge clk);
    sa = 0; sb = 0;
    @(negedge clk);
    if (port_b && !m_ctrl[1]) begin m_b = v; m_fb = 1; end
    if (!port_b && !m_ctrl[0]) begin m_a = v; m_fa = 1; end
  endtask

  initial begin
    #3000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; cs = 0; rd = 0; wr = 0; sa = 0; sb = 0; addr = 0;
    ain = 8'h00; bin = 8'h00; drv = 0; drv_val = 0;
    m_ctrl = 0; m_a = 0; m_b = 0; m_fa = 0; m_fb = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    pins_chk();
    bus_read(2'd2, "R10 ctrl reset");
    bus_read(2'd3, "R10 status reset");
    // R1 idle bus floats (pulled high)
    #5 chk("R1 bus idle", bus, 8'hFF);
    // R2/R3 decode
    bus_write(2'd2, 8'h5C);
    bus_read(2'd2, "R3 ctrl readback");
    bus_write(2'd0, 8'h12);
    bus_write(2'd1, 8'h34);
    bus_read(2'd0, "R2 port A");
    bus_read(2'd1, "R2 port B");
    pins_chk();
    // R1 deselected write does nothing
    @(negedge clk); cs = 0; wr = 1; addr = 2'd2; drv = 1; drv_val = 8'hA7;
    @(negedge clk); wr = 0; drv = 0;
    bus_read(2'd2, "R1 deselected write");
    // R9 read and write together
    @(negedge clk); cs = 1; rd = 1; wr = 1; addr = 2'd2;
    #5 chk("R9 bus not driven", bus, 8'hFF);
    @(negedge clk); cs = 0; rd = 0; wr = 0;
    bus_read(2'd2, "R9 ctrl unchanged");
    // R5 input capture
    strobe(0, 8'h9A);
    bus_read(2'd3, "R5 flag A set");
    bus_read(2'd0, "R5 port A captured");
    bus_read(2'd3, "R6 flag A cleared");
    strobe(1, 8'h66);
    bus_read(2'd3, "R5 flag B set");
    // R7 status write ignored
    bus_write(2'd3, 8'hFC);
    bus_read(2'd3, "R7 status unchanged");
    bus_read(2'd2, "R7 ctrl unchanged");
    bus_read(2'd1, "R6 port B read");
    // R8 output mode ignores strobe
    bus_write(2'd2, 8'h03);
    bus_write(2'd0, 8'hC3);
    strobe(0, 8'h11);
    strobe(1, 8'h22);
    bus_read(2'd0, "R8 port A held");
    bus_read(2'd3, "R8 no flags");
    pins_chk();
    // R6 capture wins over same-cycle read
    bus_write(2'd2, 8'h00);
    @(negedge clk);
    cs = 1; rd = 1; addr = 2'd0; ain = 8'h7E; sa = 1;
    #5 chk("R6 read during capture", bus, m_a);
    @(negedge clk);
    cs = 0; rd = 0; sa = 0; m_a = 8'h7E; m_fa = 1;
    bus_read(2'd3, "R6 capture beats clear");
    bus_read(2'd0, "R6 captured value");
    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: bus_write(2'($urandom_range(0, 3)), 8'($urandom));
        1: bus_read(2'($urandom_range(0, 3)), "R3 random read");
        2: strobe(1'($urandom_range(0, 1)), 8'($urandom));
        default: pins_chk();
      endcase
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule